// File: doc/BRIEF.md
# Double-Word Shift and Normalize Unit

This unit shifts a 48-bit value held as two 24-bit halves: an upper half (the sign half) and a lower half. A request gives a group (right or left), a 3-bit sub-operation code, a 9-bit count and the starting contents of both halves and of a 24-bit index register. The unit then moves the value one place per clock. It supports arithmetic, logical and circular shifts in either direction, plus two normalize variants. A normalize variant stops as soon as the upper half's two top bits differ and takes the number of places moved off the index register.

Control is a three-state machine. The states are IDLE, EXEC and DONE. The transitions are:

- LAUNCH: IDLE to EXEC, when a legal request is accepted. The operands load at this edge.
- REJECT: IDLE to DONE, when the request carries an unrecognised code. Nothing loads.
- STEP: EXEC to EXEC, which moves one place.
- FINISH: EXEC to DONE, taken when no steps remain or when the normalize stop test holds.
- RETIRE: DONE to IDLE.

The results stay on the output ports until the next accepted request.

Top module: `dws_unit`

## Requirements
- R1: A count above 48 behaves exactly as a count of 48, in every sub-operation of both groups.
- R2: Right group, code 3'b000: arithmetic right shift of the 48-bit value. The vacated top bits are filled with bit 23 of the upper half.
- R3: Right group, code 3'b101: logical right shift of the 48-bit value, with the vacated top bits filled with zeros.
- R4: Code 3'b100 rotates the 48-bit value, to the right in the right group and to the left in the left group. A rotate by 0 or by exactly 48 leaves both halves unchanged and performs no step. A left rotate by n equals a right rotate by 48-n.
- R5: Left group, code 3'b000: left shift of the 48-bit value. Bit 23 of the lower half enters bit 0 of the upper half, and the lower half fills with zeros.
- R6: Left group, code 3'b010 (normalize) shifts as in R5, up to the clamped count. Before each step it stops if bit 23 and bit 22 of the upper half differ. The index output is the index input minus the steps taken, modulo 2^24. Every other legal operation returns the index input unchanged.
- R7: Left group, code 3'b110 (cycle normalize) uses the stop test, the step limit and the index update of R6. Each of its steps is a 1-place left rotate of the 48-bit value.
- R8: A count of zero returns both halves and the index unchanged for every legal sub-operation.
- R9: `done` is high for exactly one cycle. With n steps performed, it is high in cycle n+2, counting the cycle in which `start` is sampled as cycle 1. `busy` is high exactly while steps may still run, and is never high together with `done`.
- R10: Any other code is illegal. Illegal codes are 3'b001, 3'b010, 3'b011, 3'b110 and 3'b111 in the right group, and 3'b001, 3'b011, 3'b101 and 3'b111 in the left group. An illegal request raises `done` and `illegal` together in cycle 1 and leaves all three result outputs at their previous values.
- R11: `start` is ignored while the unit is in EXEC or DONE. The running operation's results are unaffected, and the outputs change only when a request is accepted or while a step runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled in IDLE |
| left_grp | input | 1 | 1 selects the left group, 0 the right group |
| subop | input | 3 | Sub-operation code |
| count | input | 9 | Requested number of places |
| a_in | input | 24 | Upper half operand |
| b_in | input | 24 | Lower half operand |
| x_in | input | 24 | Index register operand |
| busy | output | 1 | High in EXEC |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with `done` for an unrecognised code |
| a_out | output | 24 | Upper half result |
| b_out | output | 24 | Lower half result |
| x_out | output | 24 | Index result |

## Verification
The bench builds the unit with its default parameters: 24-bit halves and a 9-bit count. With these values a request can reach the full 48-step walk, where an all-zero normalize runs to the limit and wraps the index below zero. The same width also lets counts from 49 up to 511 be requested, so the clamp is exercised well past its threshold. Latency is measured for every request and compared with the step count that a bench-side model derives. The model also provides the left/right rotate equivalence and the 0/48 rotate no-op cases.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [2:0] {
        K_SRA,
        K_SRL,
        K_RRC,
        K_SLA,
        K_NRM,
        K_RLC,
        K_CNRM,
        K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXEC,
        S_DONE
    } state_e;

    function automatic kind_e decode_op(input logic left, input logic [2:0] code);
        kind_e k;
        k = K_BAD;
        if (!left) begin
            case (code)
                3'b000:  k = K_SRA;
                3'b101:  k = K_SRL;
                3'b100:  k = K_RRC;
                default: k = K_BAD;
            endcase
        end else begin
            case (code)
                3'b000:  k = K_SLA;
                3'b010:  k = K_NRM;
                3'b100:  k = K_RLC;
                3'b110:  k = K_CNRM;
                default: k = K_BAD;
            endcase
        end
        return k;
    endfunction

    function automatic logic is_norm(input kind_e k);
        return (k == K_NRM) || (k == K_CNRM);
    endfunction

endpackage

// File: rtl/dws_clamp.sv
module dws_clamp
    import dws_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int MAX_STEPS = 48,
    parameter int REM_W     = 6
) (
    input  logic [CNT_W-1:0] count,
    input  kind_e            kind,
    output logic [REM_W-1:0] steps_o
);
    logic [REM_W-1:0] limited;
    logic             is_rot;

    always_comb begin
        if (count > CNT_W'(MAX_STEPS)) limited = REM_W'(MAX_STEPS);
        else                           limited = count[REM_W-1:0];
        is_rot = (kind == K_RRC) || (kind == K_RLC);
        if (is_rot && (limited == REM_W'(MAX_STEPS))) steps_o = '0;
        else                                          steps_o = limited;
    end
endmodule

// File: rtl/dws_step.sv
module dws_step
    import dws_pkg::*;
#(
    parameter int HALF_W = 24
) (
    input  kind_e             kind,
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    output logic [HALF_W-1:0] a_nx,
    output logic [HALF_W-1:0] b_nx,
    output logic              halt
);
    localparam int DW = 2 * HALF_W;

    logic [DW-1:0] wide;
    logic [DW-1:0] nxt;

    always_comb begin
        wide = {a, b};
        unique case (kind)
            K_SRA:         nxt = {a[HALF_W-1], wide[DW-1:1]};
            K_SRL:         nxt = {1'b0, wide[DW-1:1]};
            K_RRC:         nxt = {wide[0], wide[DW-1:1]};
            K_SLA, K_NRM:  nxt = {wide[DW-2:0], 1'b0};
            K_RLC, K_CNRM: nxt = {wide[DW-2:0], wide[DW-1]};
            default:       nxt = wide;
        endcase
        a_nx = nxt[DW-1:HALF_W];
        b_nx = nxt[HALF_W-1:0];
        halt = is_norm(kind) && (a[HALF_W-1] ^ a[HALF_W-2]);
    end
endmodule

// File: rtl/dws_unit.sv
module dws_unit
    import dws_pkg::*;
#(
    parameter int HALF_W = 24,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              left_grp,
    input  logic [2:0]        subop,
    input  logic [CNT_W-1:0]  count,
    input  logic [HALF_W-1:0] a_in,
    input  logic [HALF_W-1:0] b_in,
    input  logic [HALF_W-1:0] x_in,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [HALF_W-1:0] a_out,
    output logic [HALF_W-1:0] b_out,
    output logic [HALF_W-1:0] x_out
);
    localparam int MAX_STEPS = 2 * HALF_W;
    localparam int REM_W     = $clog2(MAX_STEPS + 1);

    state_e            state, state_nx;
    kind_e             kind_in, kind_r;
    logic [REM_W-1:0]  steps_in, rem_r;
    logic [HALF_W-1:0] a_r, b_r, x_r, a_nx, b_nx;
    logic              halt, bad_r, step_go;

    assign kind_in = decode_op(left_grp, subop);

    dws_clamp #(.CNT_W(CNT_W), .MAX_STEPS(MAX_STEPS), .REM_W(REM_W)) u_clamp (
        .count   (count),
        .kind    (kind_in),
        .steps_o (steps_in)
    );

    dws_step #(.HALF_W(HALF_W)) u_step (
        .kind (kind_r),
        .a    (a_r),
        .b    (b_r),
        .a_nx (a_nx),
        .b_nx (b_nx),
        .halt (halt)
    );

    assign step_go = (state == S_EXEC) && (rem_r != '0) && !halt;

    // next-state selection: LAUNCH, REJECT, STEP, FINISH, RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = (kind_in == K_BAD) ? S_DONE : S_EXEC;
            S_EXEC: if (!step_go) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r    <= '0;
            b_r    <= '0;
            x_r    <= '0;
            rem_r  <= '0;
            kind_r <= K_BAD;
            bad_r  <= 1'b0;
        end else if (state == S_IDLE && start) begin
            bad_r <= (kind_in == K_BAD);
            if (kind_in != K_BAD) begin
                a_r    <= a_in;
                b_r    <= b_in;
                x_r    <= x_in;
                rem_r  <= steps_in;
                kind_r <= kind_in;
            end
        end else if (step_go) begin
            a_r   <= a_nx;
            b_r   <= b_nx;
            rem_r <= rem_r - REM_W'(1);
            if (is_norm(kind_r)) x_r <= x_r - HALF_W'(1);
        end
    end

    always_comb begin
        busy    = (state == S_EXEC);
        done    = (state == S_DONE);
        illegal = (state == S_DONE) && bad_r;
        a_out   = a_r;
        b_out   = b_r;
        x_out   = x_r;
    end
endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
    parameter int HALF_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic [HALF_W-1:0] a_out,
    input logic [HALF_W-1:0] b_out,
    input logic [HALF_W-1:0] x_out
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r9_legal_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |-> $past(busy));

    a_r10_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    a_r10_illegal_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !$past(busy));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(start)) |-> $stable({a_out, b_out, x_out}));
endmodule

bind dws_unit dws_chk #(.HALF_W(HALF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .a_out   (a_out),
    .b_out   (b_out),
    .x_out   (x_out)
);

// File: tb/sim_dws_unit.sv
`timescale 1ns/1ps
module sim_dws_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        left_grp = 1'b0;
    logic [2:0]  subop = '0;
    logic [8:0]  count = '0;
    logic [23:0] a_in = '0, b_in = '0, x_in = '0;
    logic        busy, done, illegal;
    logic [23:0] a_out, b_out, x_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dws_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .left_grp(left_grp),
        .subop(subop), .count(count), .a_in(a_in), .b_in(b_in), .x_in(x_in),
        .busy(busy), .done(done), .illegal(illegal),
        .a_out(a_out), .b_out(b_out), .x_out(x_out)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // independent model built from the requirement text
    task automatic model(input logic left, input logic [2:0] op, input logic [8:0] cnt,
                         input logic [23:0] a, input logic [23:0] b, input logic [23:0] x,
                         output logic [23:0] ea, output logic [23:0] eb, output logic [23:0] ex,
                         output int steps, output bit bad);
        logic [47:0] v;
        int c;
        v = {a, b};
        c = (cnt > 9'd48) ? 48 : int'(cnt);
        ex = x;
        bad = 1'b0;
        steps = c;
        if (!left && op == 3'b000)      v = 48'($signed(v) >>> c);
        else if (!left && op == 3'b101) v = v >> c;
        else if (op == 3'b100) begin
            if (c == 48) steps = 0;
            if (!left) v = 48'({v, v} >> c);
            else       v = 48'({v, v} >> ((48 - c) % 48));
        end else if (left && op == 3'b000) v = v << c;
        else if (left && (op == 3'b010 || op == 3'b110)) begin
            steps = 0;
            while (steps < c && (v[47] == v[46])) begin
                v = (op == 3'b010) ? (v << 1) : {v[46:0], v[47]};
                steps++;
            end
            ex = x - 24'(steps);
        end else begin
            bad = 1'b1;
            steps = 0;
        end
        ea = v[47:24];
        eb = v[23:0];
    endtask

    task automatic run_op(input string tag, input logic left, input logic [2:0] op,
                          input logic [8:0] cnt, input logic [23:0] a,
                          input logic [23:0] b, input logic [23:0] x);
        logic [23:0] ea, eb, ex;
        int steps, cyc;
        bit bad;
        model(left, op, cnt, a, b, x, ea, eb, ex, steps, bad);
        if (bad) begin
            ea = a_out; eb = b_out; ex = x_out;
        end
        @(negedge clk);
        left_grp = left; subop = op; count = cnt;
        a_in = a; b_in = b; x_in = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a_in = ~a; b_in = ~b; x_in = ~x;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " upper"}, 48'(a_out), 48'(ea));
        check({tag, " lower"}, 48'(b_out), 48'(eb));
        check({tag, " index"}, 48'(x_out), 48'(ex));
        check({tag, " R9 latency"}, 48'(cyc), bad ? 48'd1 : 48'(steps + 2));
        check({tag, " R10 illegal flag"}, 48'(illegal), 48'(bad));
        @(negedge clk);
        check({tag, " R9 done one cycle"}, 48'(done), 48'd0);
    endtask

    task automatic t_reset;
        check("R9 reset busy", 48'(busy), 48'd0);
        check("R9 reset done", 48'(done), 48'd0);
        check("R10 reset illegal", 48'(illegal), 48'd0);
        check("R9 reset outputs", 48'({a_out, b_out} ^ 48'(x_out)), 48'd0);
    endtask

    task automatic t_right;
        run_op("R2 sra 7", 1'b0, 3'b000, 9'd7, 24'h812345, 24'h6789AB, 24'h000111);
        run_op("R2 sra positive 30", 1'b0, 3'b000, 9'd30, 24'h5A5A5A, 24'hC3C3C3, 24'h0);
        run_op("R1 sra 100", 1'b0, 3'b000, 9'd100, 24'h900000, 24'h000001, 24'h0);
        run_op("R3 srl 13", 1'b0, 3'b101, 9'd13, 24'hF0F0F0, 24'h123456, 24'h777777);
        run_op("R3 srl 48", 1'b0, 3'b101, 9'd48, 24'hFFFFFF, 24'hFFFFFF, 24'h0);
        run_op("R1 srl 511", 1'b0, 3'b101, 9'd511, 24'hFFFFFF, 24'hFFFFFF, 24'h0);
    endtask

    task automatic t_rotate;
        logic [23:0] ra, rb;
        run_op("R4 rotr 5", 1'b0, 3'b100, 9'd5, 24'h80000F, 24'h00F001, 24'h0);
        run_op("R4 rotr 48", 1'b0, 3'b100, 9'd48, 24'hABCDEF, 24'h012345, 24'h0);
        run_op("R4 R1 rotl 200", 1'b1, 3'b100, 9'd200, 24'hABCDEF, 24'h012345, 24'h0);
        run_op("R4 rotr 41", 1'b0, 3'b100, 9'd41, 24'hC00001, 24'h8421F0, 24'h0);
        ra = a_out; rb = b_out;
        run_op("R4 rotl 7", 1'b1, 3'b100, 9'd7, 24'hC00001, 24'h8421F0, 24'h0);
        check("R4 rotl n equals rotr 48-n", {a_out, b_out}, {ra, rb});
    endtask

    task automatic t_left;
        run_op("R5 sla 10", 1'b1, 3'b000, 9'd10, 24'h00ABCD, 24'hF00FF0, 24'h000042);
        run_op("R5 R1 sla 60", 1'b1, 3'b000, 9'd60, 24'hFFFFFF, 24'hFFFFFF, 24'h0);
        run_op("R6 normalize full", 1'b1, 3'b010, 9'd48, 24'h001234, 24'h800000, 24'h000100);
        run_op("R6 normalize limited", 1'b1, 3'b010, 9'd3, 24'hFFF234, 24'h000001, 24'h000010);
        run_op("R6 normalize already", 1'b1, 3'b010, 9'd20, 24'h400000, 24'h000001, 24'h000009);
        run_op("R6 R1 normalize zero wrap", 1'b1, 3'b010, 9'd60, 24'h0, 24'h0, 24'h000005);
        run_op("R7 cycle normalize", 1'b1, 3'b110, 9'd20, 24'hFFFF80, 24'h00000F, 24'h000020);
        run_op("R7 cycle normalize ones", 1'b1, 3'b110, 9'd70, 24'hFFFFFF, 24'hFFFFFF, 24'h000001);
    endtask

    task automatic t_zero;
        run_op("R8 zero sra", 1'b0, 3'b000, 9'd0, 24'h876543, 24'h210FED, 24'h111111);
        run_op("R8 zero srl", 1'b0, 3'b101, 9'd0, 24'h876543, 24'h210FED, 24'h222222);
        run_op("R8 zero rotr", 1'b0, 3'b100, 9'd0, 24'h876543, 24'h210FED, 24'h333333);
        run_op("R8 zero sla", 1'b1, 3'b000, 9'd0, 24'h876543, 24'h210FED, 24'h444444);
        run_op("R8 zero normalize", 1'b1, 3'b010, 9'd0, 24'h076543, 24'h210FED, 24'h555555);
        run_op("R8 zero rotl", 1'b1, 3'b100, 9'd0, 24'h876543, 24'h210FED, 24'h666666);
        run_op("R8 zero cycle normalize", 1'b1, 3'b110, 9'd0, 24'h076543, 24'h210FED, 24'h777777);
    endtask

    task automatic t_illegal;
        run_op("R8 seed", 1'b1, 3'b000, 9'd1, 24'h123456, 24'h789ABC, 24'h0DEF01);
        run_op("R10 right 3", 1'b0, 3'b011, 9'd5, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF);
        run_op("R10 left 1", 1'b1, 3'b001, 9'd9, 24'h0, 24'h0, 24'h0);
        run_op("R10 right 7", 1'b0, 3'b111, 9'd0, 24'hAAAAAA, 24'h555555, 24'h1);
        run_op("R10 left 5", 1'b1, 3'b101, 9'd2, 24'hAAAAAA, 24'h555555, 24'h1);
    endtask

    task automatic t_busy_ignore;
        logic [23:0] ea, eb, ex;
        int steps, cyc;
        bit bad;
        model(1'b0, 3'b101, 9'd40, 24'hDEADBE, 24'hEF0123, 24'h000033, ea, eb, ex, steps, bad);
        @(negedge clk);
        left_grp = 1'b0; subop = 3'b101; count = 9'd40;
        a_in = 24'hDEADBE; b_in = 24'hEF0123; x_in = 24'h000033; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        repeat (5) begin @(negedge clk); cyc++; end
        left_grp = 1'b1; subop = 3'b010; count = 9'd3;
        a_in = 24'h000001; b_in = 24'h0; x_in = 24'h0; start = 1'b1;
        @(negedge clk);
        cyc++;
        start = 1'b0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        check("R11 upper", 48'(a_out), 48'(ea));
        check("R11 lower", 48'(b_out), 48'(eb));
        check("R11 index", 48'(x_out), 48'(ex));
        check("R11 latency", 48'(cyc), 48'(steps + 2));
        // start held during DONE must also be ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 start in done ignored", 48'(busy | done), 48'd0);
        check("R11 outputs held", {a_out, b_out}, {ea, eb});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_right();
        t_rotate();
        t_left();
        t_zero();
        t_illegal();
        t_busy_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule